// File: doc/BRIEF.md
# Daisy-Chain Command Frame Transmitter

This block turns one register write for a chain of battery-monitor devices into a 32-bit serial command and sends it on a four-wire serial link. The host side of the block provides four things: a 5-bit device address, a 6-bit register address, an 8-bit value and a broadcast flag. The block packs these into a frame and adds an 8-bit check code computed over the header. It then shifts the frame out most-significant bit first. Clock polarity is 0 and data is launched on the rising serial-clock edge (SPI mode 1).

The serial clock is derived from the system clock through a half-period divider, `HALF_DIV`. With the default of 36 on a 50 MHz clock, the serial clock runs at about 694 kHz, just under the 700 kHz ceiling the devices tolerate. A start pulse launches a frame. While the frame is in flight, `busy` stays high and further start pulses are dropped. A one-cycle `done` marks the end of the frame, and an idle gap of one bit period follows before the next frame can begin.

The check code is not a plain CRC over the frame. Each byte step uses the table form of CRC-8 with generator 0x2F and a zero seed. The covered 21-bit header is split into bytes, and the last byte is XORed in without a further table step.

Top module: `chain_cmd_tx`

## Requirements
- R1: Frame layout: device address in bits 31:27, register address in bits 26:21, value in bits 20:13, broadcast flag in bit 12, and bit 11 always 0.
- R2: Check code placement and inputs. The code sits in bits 10:3. It is computed over frame bits 31:11 as a 21-bit value C. Let B2 = C[20:16] zero-extended to 8 bits, B1 = C[15:8] and B0 = C[7:0]. The code equals T(T(B2) ^ B1) ^ B0.
- R3: Bits 2:0 of every frame carry the constant 3'b010 and play no part in the check code.
- R4: Serial clock and data timing. `sclk` is low whenever `cs_n` is high. `mosi` changes only on a rising `sclk` edge or when `cs_n` changes. `mosi` is stable across every falling `sclk` edge. Bit 31 is sent first.
- R5: `cs_n` is low for exactly 64*HALF_DIV system cycles per frame and carries exactly 32 falling `sclk` edges. `busy` is high whenever `cs_n` is low.
- R6: A start pulse while `busy` is high is ignored. The frame in flight is unchanged, and no extra frame follows.
- R7: `done` is high for exactly one cycle, namely the first cycle in which `cs_n` is high again. `busy` then stays high for 2*HALF_DIV cycles counted from that cycle, which forms the inter-frame gap.
- R8: During and right after synchronous reset, the outputs are `cs_n`=1, `sclk`=0, `mosi`=0, `busy`=0 and `done`=0. This holds even when reset arrives mid-frame.
- R9: Each high and each low phase of `sclk` inside a frame lasts exactly HALF_DIV system cycles.

T is the MSB-first CRC-8 of one byte, with generator x^8+x^5+x^3+x^2+x+1 (0x2F) and a zero seed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch a frame when idle |
| dev_addr | input | 5 | Target device address (0 = head of chain, 0x1F = highest/all) |
| reg_addr | input | 6 | Target register address |
| wr_data | input | 8 | Value to write |
| bcast | input | 1 | Broadcast flag placed in frame bit 12 |
| busy | output | 1 | Frame or trailing gap in progress |
| done | output | 1 | One-cycle end-of-frame pulse |
| sclk | output | 1 | Serial clock, idle low |
| cs_n | output | 1 | Active-low chip select |
| mosi | output | 1 | Serial data out, MSB first |

## Verification
The bench goes after the places where the check code most easily goes wrong. An all-zero header must yield code 0. The highest-address, zero-data frame must equal 0xF800030A exactly. An all-ones header exercises the zero-extended top byte. A design that ran the table step on the last byte, or folded the trailer into the coverage, would produce a different code byte for all of these. On the link side, the bench counts the cycles of every `sclk` phase and of every `cs_n` window, and it watches when `mosi` moves. This exposes an off-by-one divider, a 31- or 33-bit frame, or data launched on the sampling edge. A start pulse during a frame, a `done` misplaced by one cycle, and a reset arriving mid-frame are each checked at the pins.

// File: rtl/chain_cmd_pkg.sv
package chain_cmd_pkg;

    localparam int FRAME_W = 32;
    localparam int DEV_W   = 5;
    localparam int REG_W   = 6;
    localparam int DATA_W  = 8;
    localparam int CODE_W  = 8;
    // header fields plus the always-zero bit 11
    localparam int COVER_W = DEV_W + REG_W + DATA_W + 2;

    localparam logic [CODE_W-1:0] CHK_POLY = 8'h2F;
    localparam logic [2:0]        TRAILER  = 3'b010;

    typedef struct packed {
        logic [DEV_W-1:0]  dev;
        logic [REG_W-1:0]  regaddr;
        logic [DATA_W-1:0] data;
        logic              bcast;
    } cmd_t;

    typedef struct packed {
        logic [DEV_W-1:0]  dev;
        logic [REG_W-1:0]  regaddr;
        logic [DATA_W-1:0] data;
        logic              bcast;
        logic              pad;
        logic [CODE_W-1:0] code;
        logic [2:0]        trailer;
    } frame_t;

    typedef enum logic [1:0] {
        TX_IDLE,
        TX_SHIFT,
        TX_GAP
    } tx_state_e;

    // One byte through the CRC-8 generator, zero seed, byte-at-once form.
    function automatic logic [CODE_W-1:0] crc8_byte(input logic [CODE_W-1:0] x);
        logic [CODE_W-1:0] r;
        r = x;
        for (int i = 0; i < 8; i++) begin
            r = r[CODE_W-1] ? ((r << 1) ^ CHK_POLY) : (r << 1);
        end
        return r;
    endfunction

endpackage

// File: rtl/chain_check_code.sv
module chain_check_code
    import chain_cmd_pkg::*;
#(
    parameter int COVER_BITS = COVER_W
) (
    input  logic [COVER_BITS-1:0] covered,
    output logic [CODE_W-1:0]     code
);
    localparam int NBYTES = (COVER_BITS + 7) / 8;
    localparam int PAD_W  = NBYTES * 8;

    logic [PAD_W-1:0]  padded;
    logic [CODE_W-1:0] stage [NBYTES];

    assign padded   = PAD_W'(covered);
    assign stage[0] = padded[PAD_W-1 -: 8];

    // Each step runs the table on the running value and folds in the next
    // byte; the final byte is folded in without another table step.
    for (genvar k = 0; k < NBYTES - 1; k++) begin : g_step
        assign stage[k+1] = crc8_byte(stage[k]) ^ padded[(NBYTES-2-k)*8 +: 8];
    end

    assign code = stage[NBYTES-1];

endmodule

// File: rtl/chain_frame_pack.sv
module chain_frame_pack
    import chain_cmd_pkg::*;
(
    input  cmd_t   cmd,
    output frame_t frame
);
    logic [COVER_W-1:0] covered;
    logic [CODE_W-1:0]  code;

    assign covered = {cmd, 1'b0};

    chain_check_code #(.COVER_BITS(COVER_W)) u_code (
        .covered (covered),
        .code    (code)
    );

    always_comb begin
        frame.dev     = cmd.dev;
        frame.regaddr = cmd.regaddr;
        frame.data    = cmd.data;
        frame.bcast   = cmd.bcast;
        frame.pad     = 1'b0;
        frame.code    = code;
        frame.trailer = TRAILER;
    end

endmodule

// File: rtl/chain_spi_shifter.sv
module chain_spi_shifter
    import chain_cmd_pkg::*;
#(
    parameter int HALF_DIV = 36
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [FRAME_W-1:0] frame_i,
    output logic               busy,
    output logic               done,
    output logic               sclk,
    output logic               cs_n,
    output logic               mosi
);
    localparam int BIT_CYC = 2 * HALF_DIV;
    localparam int CNT_W   = $clog2(BIT_CYC + 1);
    localparam int IDX_W   = $clog2(FRAME_W);
    localparam int LOW_CYC = FRAME_W * BIT_CYC;
    localparam int LOW_W   = $clog2(LOW_CYC + 2);

    tx_state_e          state;
    logic [CNT_W-1:0]   div_cnt;
    logic [IDX_W-1:0]   bit_idx;
    logic               hi_phase;
    logic [FRAME_W-1:0] shreg;

    assign busy = (state != TX_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= TX_IDLE;
            div_cnt  <= '0;
            bit_idx  <= '0;
            hi_phase <= 1'b0;
            shreg    <= '0;
            sclk     <= 1'b0;
            cs_n     <= 1'b1;
            mosi     <= 1'b0;
            done     <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state)
                TX_IDLE: begin
                    if (start) begin
                        shreg    <= frame_i;
                        state    <= TX_SHIFT;
                        cs_n     <= 1'b0;
                        sclk     <= 1'b1;
                        hi_phase <= 1'b1;
                        mosi     <= frame_i[FRAME_W-1];
                        bit_idx  <= '0;
                        div_cnt  <= '0;
                    end
                end
                TX_SHIFT: begin
                    if (div_cnt == CNT_W'(HALF_DIV - 1)) begin
                        div_cnt <= '0;
                        if (hi_phase) begin
                            sclk     <= 1'b0;
                            hi_phase <= 1'b0;
                        end else if (bit_idx == IDX_W'(FRAME_W - 1)) begin
                            cs_n  <= 1'b1;
                            mosi  <= 1'b0;
                            done  <= 1'b1;
                            state <= TX_GAP;
                        end else begin
                            bit_idx  <= bit_idx + 1'b1;
                            sclk     <= 1'b1;
                            hi_phase <= 1'b1;
                            mosi     <= shreg[FRAME_W-2-int'(bit_idx)];
                        end
                    end else begin
                        div_cnt <= div_cnt + 1'b1;
                    end
                end
                TX_GAP: begin
                    if (div_cnt == CNT_W'(BIT_CYC - 1)) begin
                        div_cnt <= '0;
                        state   <= TX_IDLE;
                    end else begin
                        div_cnt <= div_cnt + 1'b1;
                    end
                end
                default: state <= TX_IDLE;
            endcase
        end
    end

    // Window counter backing the chip-select length check.
    logic [LOW_W-1:0] low_cnt;
    always_ff @(posedge clk) begin
        if (rst)        low_cnt <= '0;
        else if (!cs_n) low_cnt <= low_cnt + 1'b1;
        else            low_cnt <= '0;
    end

    p_idle_clk_low_r4: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> !sclk);

    p_mosi_hold_r4: assert property (@(posedge clk) disable iff (rst)
        $fell(sclk) |-> $stable(mosi));

    p_cs_len_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(cs_n) |-> (low_cnt == LOW_W'(LOW_CYC)));

    p_cs_busy_r5: assert property (@(posedge clk) disable iff (rst)
        !cs_n |-> busy);

    p_start_ignored_r6: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> $stable(shreg));

    p_done_at_cs_rise_r7: assert property (@(posedge clk) disable iff (rst)
        done |-> $rose(cs_n));

    p_done_single_r7: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

endmodule

// File: rtl/chain_cmd_tx.sv
module chain_cmd_tx
    import chain_cmd_pkg::*;
#(
    parameter int HALF_DIV = 36
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [4:0]   dev_addr,
    input  logic [5:0]   reg_addr,
    input  logic [7:0]   wr_data,
    input  logic         bcast,
    output logic         busy,
    output logic         done,
    output logic         sclk,
    output logic         cs_n,
    output logic         mosi
);
    cmd_t   cmd;
    frame_t frame;

    always_comb begin
        cmd.dev     = dev_addr;
        cmd.regaddr = reg_addr;
        cmd.data    = wr_data;
        cmd.bcast   = bcast;
    end

    chain_frame_pack u_pack (
        .cmd   (cmd),
        .frame (frame)
    );

    chain_spi_shifter #(.HALF_DIV(HALF_DIV)) u_shift (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .frame_i (frame),
        .busy    (busy),
        .done    (done),
        .sclk    (sclk),
        .cs_n    (cs_n),
        .mosi    (mosi)
    );

endmodule

// File: tb/chain_cmd_tx_test.sv
module chain_cmd_tx_test;

    localparam int HALF = 3;
    localparam int BITC = 2 * HALF;
    localparam int NVEC = 8;

    // {dev[4:0], reg[5:0], data[7:0], bcast}
    localparam logic [19:0] VEC [NVEC] = '{
        {5'h1F, 6'h00, 8'h00, 1'b0},
        {5'h00, 6'h00, 8'h00, 1'b0},
        {5'h1F, 6'h3F, 8'hFF, 1'b1},
        {5'h00, 6'h0D, 8'hFF, 1'b1},
        {5'h03, 6'h14, 8'hA5, 1'b0},
        {5'h10, 6'h1B, 8'h5A, 1'b1},
        {5'h07, 6'h0E, 8'h3C, 1'b1},
        {5'h15, 6'h2A, 8'h81, 1'b0}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic [4:0] dev_addr = '0;
    logic [5:0] reg_addr = '0;
    logic [7:0] wr_data = '0;
    logic bcast = 1'b0;
    logic busy, done, sclk, cs_n, mosi;

    always #10 clk = ~clk;

    chain_cmd_tx #(.HALF_DIV(HALF)) uut (
        .clk(clk), .rst(rst), .start(start),
        .dev_addr(dev_addr), .reg_addr(reg_addr), .wr_data(wr_data), .bcast(bcast),
        .busy(busy), .done(done), .sclk(sclk), .cs_n(cs_n), .mosi(mosi)
    );

    int n_chk = 0;
    int n_bad = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Bit-serial reference of one CRC-8 byte step.
    function automatic logic [7:0] ref_t(input logic [7:0] x);
        logic [7:0] c;
        logic fb;
        c = 8'h00;
        for (int i = 7; i >= 0; i--) begin
            fb = c[7] ^ x[i];
            c = {c[6:0], 1'b0};
            if (fb) c = c ^ 8'h2F;
        end
        return c;
    endfunction

    function automatic logic [7:0] ref_code(input logic [20:0] cov);
        logic [7:0] b2, b1, b0;
        b2 = {3'b000, cov[20:16]};
        b1 = cov[15:8];
        b0 = cov[7:0];
        return ref_t(ref_t(b2) ^ b1) ^ b0;
    endfunction

    // ---------------- pin monitor, sampled on the falling system edge
    logic        p_sclk = 1'b0, p_cs = 1'b1, p_mosi = 1'b0;
    logic [31:0] cap = '0, last_word = '0;
    int cs_cyc = 0, edges = 0, run = 0;
    int last_cs_len = 0, last_edges = 0;
    bit last_done_at_rise = 0;
    int frames_seen = 0, gaps_seen = 0, gap_cnt = 0, last_gap = 0;
    bit in_gap = 0;
    int viol_r4 = 0, viol_r9 = 0, done_total = 0;

    always @(negedge clk) begin
        if (!rst) begin
            if (done) done_total++;
            if (cs_n && sclk) viol_r4++;
            if (mosi !== p_mosi && !(sclk && !p_sclk) && (cs_n == p_cs)) viol_r4++;
            if (p_cs && !cs_n) begin
                cs_cyc = 1; edges = 0; cap = '0; run = 1;
            end else if (!cs_n) begin
                cs_cyc++;
                if (sclk != p_sclk) begin
                    if (run != HALF) viol_r9++;
                    run = 1;
                end else begin
                    run++;
                end
            end
            if (p_sclk && !sclk && !cs_n) begin
                cap = {cap[30:0], mosi};
                edges++;
            end
            if (!p_cs && cs_n) begin
                if (run != HALF) viol_r9++;
                last_word = cap; last_cs_len = cs_cyc; last_edges = edges;
                last_done_at_rise = done;
                frames_seen++;
                in_gap = 1; gap_cnt = 1;
            end else if (in_gap) begin
                if (busy) gap_cnt++;
                else begin
                    in_gap = 0; last_gap = gap_cnt; gaps_seen++;
                end
            end
        end
        p_sclk = sclk; p_cs = cs_n; p_mosi = mosi;
    end

    task automatic launch(input logic [19:0] v);
        @(negedge clk);
        while (busy) @(negedge clk);
        {dev_addr, reg_addr, wr_data, bcast} = v;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic check_frame(input logic [19:0] v);
        logic [7:0] code;
        code = ref_code({v, 1'b0});
        chk(last_word[31:12] == v,      "R1 header fields", {12'h0, last_word[31:12]}, {12'h0, v});
        chk(last_word[11] == 1'b0,      "R1 bit 11 zero",   {31'h0, last_word[11]}, 32'h0);
        chk(last_word[10:3] == code,    "R2 check code",    {24'h0, last_word[10:3]}, {24'h0, code});
        chk(last_word[2:0] == 3'b010,   "R3 trailer",       {29'h0, last_word[2:0]}, 32'h2);
        chk(last_cs_len == 64 * HALF,   "R5 cs_n low cycles", last_cs_len, 64 * HALF);
        chk(last_edges == 32,           "R5 falling edges",  last_edges, 32);
        chk(last_done_at_rise == 1'b1,  "R7 done at cs rise", {31'h0, last_done_at_rise}, 32'h1);
        chk(last_gap == BITC,           "R7 gap busy cycles", last_gap, BITC);
        chk(viol_r4 == 0,               "R4 mosi/sclk timing", viol_r4, 0);
        chk(viol_r9 == 0,               "R9 sclk phase length", viol_r9, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int f0, g0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R8: reset state
        chk({cs_n, sclk, mosi, busy, done} == 5'b10000, "R8 reset outputs",
            {27'h0, cs_n, sclk, mosi, busy, done}, 32'h10);
        rst = 1'b0;

        // table walk
        for (int i = 0; i < NVEC; i++) begin
            f0 = gaps_seen;
            launch(VEC[i]);
            wait (gaps_seen == f0 + 1);
            check_frame(VEC[i]);
            if (i == 0) chk(last_word == 32'hF800030A, "R2 highest-address frame", last_word, 32'hF800030A);
            if (i == 1) chk(last_word == 32'h00000002, "R2 zero header frame", last_word, 32'h00000002);
        end
        chk(done_total == NVEC, "R7 one done per frame", done_total, NVEC);

        // R6: start during a frame is ignored
        f0 = frames_seen;
        g0 = gaps_seen;
        launch(VEC[4]);
        repeat (20) @(negedge clk);
        {dev_addr, reg_addr, wr_data, bcast} = VEC[5];
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait (gaps_seen == g0 + 1);
        check_frame(VEC[4]);
        repeat (5 * BITC) @(negedge clk);
        chk(frames_seen == f0 + 1, "R6 no extra frame", frames_seen, f0 + 1);
        chk(cs_n == 1'b1 && busy == 1'b0, "R6 link idle after ignored start",
            {30'h0, cs_n, busy}, 32'h2);

        // R8: reset in the middle of a frame
        launch(VEC[6]);
        repeat (40) @(negedge clk);
        chk(cs_n == 1'b0, "R8 frame in flight before reset", {31'h0, cs_n}, 32'h0);
        rst = 1'b1;
        @(negedge clk);
        chk({cs_n, sclk, mosi, busy, done} == 5'b10000, "R8 mid-frame reset",
            {27'h0, cs_n, sclk, mosi, busy, done}, 32'h10);
        repeat (2) @(negedge clk);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule